// File: doc/BRIEF.md
# Range-Based Dual-Port Address Router

This block sits on the miss path of a cache. For each 32-bit physical request address it decides which of two downstream master ports the access uses. Port M1 leads to the memory controller and port M0 leads to the general interconnect. The decision is combinational. It is made against one programmable address window. The request address passes through to the output unchanged, next to a one-bit port select.

Software sets the window through two 32-bit registers on a plain register-access port. The base register holds the lower bound of the window and an enable flag. The limit register holds the upper bound. Both bounds keep only the twelve address bits above bit 19, so the window has 1 MiB granularity. The window is half-open: it includes the base and excludes the limit. After reset the window is enabled and spans 1 MiB up to 3 GiB.

Top module: `range_router`

## Requirements
- R1: After reset, a read of offset 0xC00 returns 0x00100001 and a read of offset 0xC04 returns 0xC0000000.
- R2: A write to offset 0xC00 stores write-data bits [31:20] as the window base and bit 0 as the enable flag. Bits [19:1] of that register always read as zero.
- R3: A write to offset 0xC04 stores write-data bits [31:20] as the window limit. Bits [19:0] of that register always read as zero.
- R4: When enabled, an address inside the window gives route_sel = 1 (port M1, memory side). Any address outside the window gives route_sel = 0 (port M0, interconnect side).
- R5: The window is half-open. An address equal to the base routes to M1. Base minus one and an address equal to the limit route to M0.
- R6: When the enable flag is 0, every address routes to M0 (route_sel = 0).
- R7: When base >= limit, the window is empty and every address routes to M0.
- R8: A register write accepted at a clock edge first affects route_sel in the cycle after that edge. Before that edge, the old window still decides the route.
- R9: route_addr always equals req_addr.
- R10: Writes to any offset other than 0xC00 and 0xC04 leave both registers unchanged. Reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe, accepted at the rising edge |
| reg_addr | input | 12 | Register byte offset for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| req_addr | input | 32 | Physical address of the request being routed |
| route_sel | output | 1 | 1 = memory-side port M1, 0 = interconnect port M0 |
| route_addr | output | 32 | Pass-through copy of req_addr |

## Verification
The assertions check the following on every cycle:
- the route select never points at M1 while the window is disabled or empty;
- any M1 selection lies inside the half-open bounds;
- the stored window changes only in the cycle after a write;
- the reserved read bits and unmapped offsets read as zero.

Only the bench scenarios can show the rest:
- the exact reset values;
- the boundary addresses at base, base minus one and limit;
- the one-cycle timing of a window change, observed against a request held across the write.

// File: rtl/range_router_pkg.sv
package range_router_pkg;

    localparam int ADDR_W   = 32;
    localparam int GRAN_LSB = 20;
    localparam int FIELD_W  = ADDR_W - GRAN_LSB;
    localparam int REG_AW   = 12;

    localparam logic [REG_AW-1:0] OFS_BASE  = 12'hC00;
    localparam logic [REG_AW-1:0] OFS_LIMIT = 12'hC04;

    localparam logic [FIELD_W-1:0] RST_BASE   = 12'h001;
    localparam logic [FIELD_W-1:0] RST_LIMIT  = 12'hC00;
    localparam logic               RST_ENABLE = 1'b1;

    // Bits kept by each register on a write
    localparam logic [ADDR_W-1:0] BASE_KEEP  = {{FIELD_W{1'b1}}, {(GRAN_LSB-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] LIMIT_KEEP = {{FIELD_W{1'b1}}, {GRAN_LSB{1'b0}}};

    typedef enum logic {
        PORT_FABRIC = 1'b0,
        PORT_MEMORY = 1'b1
    } port_sel_e;

    typedef struct packed {
        logic [FIELD_W-1:0] base;
        logic [FIELD_W-1:0] limit;
        logic               enable;
    } window_t;

    function automatic logic [ADDR_W-1:0] base_word(input logic [FIELD_W-1:0] b, input logic en);
        return {b, {(GRAN_LSB-1){1'b0}}, en};
    endfunction

    function automatic logic [ADDR_W-1:0] limit_word(input logic [FIELD_W-1:0] l);
        return {l, {GRAN_LSB{1'b0}}};
    endfunction

    function automatic logic [FIELD_W-1:0] page_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:GRAN_LSB];
    endfunction

endpackage

// File: rtl/range_router_regs.sv
module range_router_regs
    import range_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] rdata,
    output window_t           win
);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] limit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= base_word(RST_BASE, RST_ENABLE);
            limit_q <= limit_word(RST_LIMIT);
        end else if (wr_en) begin
            if (addr == OFS_BASE)
                base_q <= wdata & BASE_KEEP;
            if (addr == OFS_LIMIT)
                limit_q <= wdata & LIMIT_KEEP;
        end
    end

    always_comb begin
        unique case (addr)
            OFS_BASE:  rdata = base_q;
            OFS_LIMIT: rdata = limit_q;
            default:   rdata = '0;
        endcase
    end

    always_comb begin
        win.base   = page_of(base_q);
        win.limit  = page_of(limit_q);
        win.enable = base_q[0];
    end

endmodule

// File: rtl/range_router_decode.sv
module range_router_decode
    import range_router_pkg::*;
(
    input  window_t            win,
    input  logic [FIELD_W-1:0] page,
    output port_sel_e          sel
);

    logic at_or_above_base;
    logic below_limit;

    always_comb begin
        at_or_above_base = (page >= win.base);
        below_limit      = (page <  win.limit);
        // An empty window (base >= limit) never satisfies both terms
        if (win.enable && at_or_above_base && below_limit)
            sel = PORT_MEMORY;
        else
            sel = PORT_FABRIC;
    end

endmodule

// File: rtl/range_router.sv
module range_router
    import range_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              route_sel,
    output logic [ADDR_W-1:0] route_addr
);

    window_t   cfg;
    port_sel_e sel;

    range_router_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr_en),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .win   (cfg)
    );

    range_router_decode u_decode (
        .win  (cfg),
        .page (page_of(req_addr)),
        .sel  (sel)
    );

    assign route_sel  = (sel == PORT_MEMORY);
    assign route_addr = req_addr;

endmodule

// File: rtl/range_router_chk.sv
module range_router_chk
    import range_router_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic [REG_AW-1:0] reg_addr,
    input logic [ADDR_W-1:0] reg_rdata,
    input logic [ADDR_W-1:0] req_addr,
    input logic              route_sel,
    input logic [ADDR_W-1:0] route_addr,
    input window_t           cfg
);

    assert_off_means_fabric_R6: assert property (@(posedge clk) disable iff (rst)
        !cfg.enable |-> !route_sel);

    assert_empty_window_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg.base >= cfg.limit) |-> !route_sel);

    assert_memory_in_bounds_R4: assert property (@(posedge clk) disable iff (rst)
        route_sel |-> (req_addr >= limit_word(cfg.base)) && (req_addr < limit_word(cfg.limit)));

    assert_cfg_held_without_write_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(reg_wr_en) |-> $stable(cfg));

    assert_base_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_BASE) |-> (reg_rdata[GRAN_LSB-1:1] == '0));

    assert_limit_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_LIMIT) |-> (reg_rdata[GRAN_LSB-1:0] == '0));

    assert_unmapped_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_addr != OFS_BASE && reg_addr != OFS_LIMIT) |-> (reg_rdata == '0));

    assert_addr_passthrough_R9: assert property (@(posedge clk) disable iff (rst)
        route_addr == req_addr);

endmodule

bind range_router range_router_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .req_addr   (req_addr),
    .route_sel  (route_sel),
    .route_addr (route_addr),
    .cfg        (cfg)
);

// File: tb/range_router_tb.sv
`timescale 1ns/1ps
module range_router_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = 12'h000;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [31:0] req_addr = 32'h0;
    logic        route_sel;
    logic [31:0] route_addr;

    int checks = 0;
    int errors = 0;

    range_router u_dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_addr(req_addr),
        .route_sel(route_sel), .route_addr(route_addr)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic probe(input string req, input logic [31:0] a, input logic exp);
        @(negedge clk);
        req_addr = a;
        #0.5;
        check(req, {31'b0, route_sel}, {31'b0, exp});
        check("R9", route_addr, a);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        reg_read(12'hC00, d); check("R1 base reset", d, 32'h0010_0001);
        reg_read(12'hC04, d); check("R1 limit reset", d, 32'hC000_0000);
    endtask

    task automatic t_defaults_edges;
        probe("R5 below base", 32'h000F_FFFF, 1'b0);
        probe("R5 at base", 32'h0010_0000, 1'b1);
        probe("R4 inside", 32'h4567_89AB, 1'b1);
        probe("R5 limit-1", 32'hBFFF_FFFF, 1'b1);
        probe("R5 at limit", 32'hC000_0000, 1'b0);
        probe("R4 top", 32'hFFFF_FFFF, 1'b0);
        probe("R4 zero", 32'h0000_0000, 1'b0);
    endtask

    task automatic t_fields;
        logic [31:0] d;
        reg_write(12'hC00, 32'h2345_6789);
        reg_read(12'hC00, d); check("R2 base fields", d, 32'h2340_0001);
        reg_write(12'hC04, 32'h8765_4321);
        reg_read(12'hC04, d); check("R3 limit fields", d, 32'h8760_0000);
        probe("R4 new window in", 32'h5000_0000, 1'b1);
        probe("R5 new base-1", 32'h233F_FFFF, 1'b0);
        probe("R5 new limit", 32'h8760_0000, 1'b0);
    endtask

    task automatic t_disable;
        logic [31:0] d;
        reg_write(12'hC00, 32'h2340_0000);
        reg_read(12'hC00, d); check("R6 enable cleared", d, 32'h2340_0000);
        probe("R6 disabled inside", 32'h5000_0000, 1'b0);
        probe("R6 disabled at base", 32'h2340_0000, 1'b0);
        reg_write(12'hC00, 32'h2340_0001);
        probe("R6 re-enabled", 32'h5000_0000, 1'b1);
    endtask

    task automatic t_empty;
        reg_write(12'hC00, 32'h8000_0001);
        reg_write(12'hC04, 32'h8000_0000);
        probe("R7 equal bounds", 32'h8000_0000, 1'b0);
        reg_write(12'hC04, 32'h4000_0000);
        probe("R7 inverted lo", 32'h5000_0000, 1'b0);
        probe("R7 inverted hi", 32'h9000_0000, 1'b0);
    endtask

    task automatic t_timing;
        reg_write(12'hC00, 32'h0000_0001);
        reg_write(12'hC04, 32'hC000_0000);
        @(negedge clk);
        req_addr = 32'h3000_0000;
        reg_wr_en = 1'b1; reg_addr = 12'hC04; reg_wdata = 32'h2000_0000;
        #0.5;
        check("R8 before edge", {31'b0, route_sel}, 32'd1);
        @(negedge clk);
        reg_wr_en = 1'b0;
        #0.5;
        check("R8 after edge", {31'b0, route_sel}, 32'd0);
    endtask

    task automatic t_other_offsets;
        logic [31:0] d;
        reg_write(12'hC08, 32'hFFFF_FFFF);
        reg_write(12'h000, 32'h0000_0000);
        reg_read(12'hC00, d); check("R10 base untouched", d, 32'h0000_0001);
        reg_read(12'hC04, d); check("R10 limit untouched", d, 32'h2000_0000);
        reg_read(12'hC08, d); check("R10 unmapped read", d, 32'h0);
        probe("R10 route unchanged", 32'h1FFF_FFFF, 1'b1);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_defaults_edges();
        t_fields();
        t_disable();
        t_empty();
        t_timing();
        t_other_offsets();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule